// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which of a set of interrupt sources is handed to the CPU next. Each source has a small control word with a request flag, an enable flag, a routing bit and a 4-bit priority. Each cycle the controller picks the best enabled pending source. It presents that source only when the source's priority is strictly above the level of the service now running. A presented request is held until the CPU or a transfer channel acknowledges it.

The routing bit tells the downstream request-routing stage how the grant is served. A standard grant nests: the running level is pushed onto a small stack and the granted priority becomes the new level. A transfer-channel grant only clears the flag and leaves the level alone. A return-from-interrupt pops the stack.

Software traps enter through a separate path. A trap carries its own vector number and is presented ahead of any hardware source. The CPU core, the vector table and context saving are outside the block.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every control word reads 0, the current level is 0 and no request is presented.
- R2: A source takes part in arbitration only if its request flag and enable flag are both 1 and its priority is above the current level. A source at priority 0 is therefore never presented.
- R3: Among the sources that take part, the one with the highest priority is presented. On a tie the lowest source index wins.
- R4: A pending source whose priority equals the current level is not presented.
- R5: A hardware grant carries vector SRC_VEC_BASE plus the source index. irq_xfer_o equals that source's routing bit, and irq_trap_o is 0.
- R6: Acknowledging a standard grant (routing bit 0) clears the source's flag. It also pushes the current level and sets the level to the granted priority.
- R7: Acknowledging a transfer grant (routing bit 1) clears the source's flag and leaves the level and the stack unchanged.
- R8: reti_i without an acknowledge in the same cycle pops the stack into the level. When the stack is empty, the level becomes 0.
- R9: A trap pulse latches its vector number. The trap is then presented ahead of any hardware source at any level, with irq_trap_o=1 and irq_xfer_o=0. Its acknowledge pushes the level and keeps it unchanged.
- R10: A register write replaces the whole control word of the selected source. The word layout is bit 6 route, bit 5 request, bit 4 enable, bits 3:0 priority. reg_rdata_o shows the word of the source chosen by reg_idx_i. In the same cycle a write overrides both a hardware set and an acknowledge clear.
- R11: A src_req_i pulse sets the source's flag. When it coincides with an acknowledge clear of the same source, the flag stays set.
- R12: While the stack holds STACK_DEPTH entries, no request is presented. After a pop the blocked request is presented again.
- R13: Outputs are registered: a request appears one cycle after the state that causes it. An accepted acknowledge drops irq_req_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | NUM_SRC | Hardware request pulses, one per source |
| reg_we_i | input | 1 | Control word write strobe |
| reg_idx_i | input | IDX_W | Source selected for write and read |
| reg_wdata_i | input | 7 | Control word to write |
| reg_rdata_o | output | 7 | Control word of the selected source |
| trap_i | input | 1 | Software trap pulse |
| trap_num_i | input | VEC_W | Trap vector number |
| irq_req_o | output | 1 | Request presented |
| irq_vec_o | output | VEC_W | Vector of the presented request |
| irq_xfer_o | output | 1 | Serve by transfer channel |
| irq_trap_o | output | 1 | Presented request is a trap |
| irq_ack_i | input | 1 | Acknowledge of the presented request |
| reti_i | input | 1 | Return from interrupt |
| cur_lvl_o | output | 4 | Current service level |

## Verification
The bench builds the block with eight sources and a stack depth of three. The shallow stack lets three nested traps fill the stack within a few cycles, which exercises the full-stack blocking and its release by a pop. Eight sources give enough room to hold equal-priority ties, a source at level 0, a disabled source and a transfer-routed source at the same time. These cases check tie ordering and eligibility against the running level.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef struct packed {
    logic  route;
    logic  req;
    logic  en;
    prio_t prio;
  } src_ctrl_t;
  localparam int unsigned CTRL_W = $bits(src_ctrl_t);
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SRC-1:0]          hw_set_i,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            widx_i,
  input  src_ctrl_t                   wdata_i,
  input  logic                        clr_i,
  input  logic [IDX_W-1:0]            clr_idx_i,
  output src_ctrl_t [NUM_SRC-1:0]     ctrl_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    src_ctrl_t ctrl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q <= '0;
      end else if (we_i && widx_i == IDX_W'(i)) begin
        ctrl_q <= wdata_i;
      end else if (hw_set_i[i]) begin
        ctrl_q.req <= 1'b1;
      end else if (clr_i && clr_idx_i == IDX_W'(i)) begin
        ctrl_q.req <= 1'b0;
      end
    end
    assign ctrl_o[i] = ctrl_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  src_ctrl_t [NUM_SRC-1:0] ctrl_i,
  input  prio_t                   cur_lvl_i,
  output logic                    win_valid_o,
  output logic [IDX_W-1:0]        win_idx_o,
  output prio_t                   win_prio_o,
  output logic                    win_route_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = '0;
    win_route_o = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (ctrl_i[i].req && ctrl_i[i].en && ctrl_i[i].prio > cur_lvl_i &&
          (!win_valid_o || ctrl_i[i].prio > win_prio_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_prio_o  = ctrl_i[i].prio;
        win_route_o = ctrl_i[i].route;
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  logic  pop_i,
  input  prio_t new_lvl_i,
  output prio_t lvl_o,
  output logic  full_o
);
  prio_t             stk_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  prio_t             lvl_q;

  assign full_o = (cnt_q == CNT_W'(DEPTH));
  assign lvl_o  = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (push_i && !full_o) begin
      stk_q[PTR_W'(cnt_q)] <= lvl_q;
      cnt_q                <= cnt_q + 1'b1;
      lvl_q                <= new_lvl_i;
    end else if (pop_i) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        lvl_q <= stk_q[PTR_W'(cnt_q - 1'b1)];
      end else begin
        lvl_q <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC      = 8,
  parameter int unsigned STACK_DEPTH  = 4,
  parameter int unsigned VEC_W        = 7,
  parameter int unsigned SRC_VEC_BASE = 16,
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        src_req_i,
  input  logic                      reg_we_i,
  input  logic [IDX_W-1:0]          reg_idx_i,
  input  logic [CTRL_W-1:0]         reg_wdata_i,
  output logic [CTRL_W-1:0]         reg_rdata_o,
  input  logic                      trap_i,
  input  logic [VEC_W-1:0]          trap_num_i,
  output logic                      irq_req_o,
  output logic [VEC_W-1:0]          irq_vec_o,
  output logic                      irq_xfer_o,
  output logic                      irq_trap_o,
  input  logic                      irq_ack_i,
  input  logic                      reti_i,
  output logic [PRIO_W-1:0]         cur_lvl_o
);
  src_ctrl_t [NUM_SRC-1:0] ctrl;
  logic                    win_valid, win_route;
  logic [IDX_W-1:0]        win_idx;
  prio_t                   win_prio, cur_lvl;
  logic                    stk_full;

  logic                    req_q, xfer_q, trap_q;
  logic [VEC_W-1:0]        vec_q;
  logic [IDX_W-1:0]        idx_q;
  prio_t                   prio_q;
  logic                    trap_pend_q;
  logic [VEC_W-1:0]        trap_num_q;

  logic ack_ok, push, pop;
  assign ack_ok = irq_ack_i && req_q;
  assign push   = ack_ok && (trap_q || !xfer_q);
  assign pop    = reti_i && !ack_ok;

  irq_src_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_set_i  (src_req_i),
    .we_i      (reg_we_i),
    .widx_i    (reg_idx_i),
    .wdata_i   (src_ctrl_t'(reg_wdata_i)),
    .clr_i     (ack_ok && !trap_q),
    .clr_idx_i (idx_q),
    .ctrl_o    (ctrl)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .ctrl_i      (ctrl),
    .cur_lvl_i   (cur_lvl),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio),
    .win_route_o (win_route)
  );

  irq_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .pop_i     (pop),
    .new_lvl_i (trap_q ? cur_lvl : prio_q),
    .lvl_o     (cur_lvl),
    .full_o    (stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_pend_q <= 1'b0;
      trap_num_q  <= '0;
    end else if (trap_i) begin
      trap_pend_q <= 1'b1;
      trap_num_q  <= trap_num_i;
    end else if (ack_ok && trap_q) begin
      trap_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      xfer_q <= 1'b0;
      trap_q <= 1'b0;
      vec_q  <= '0;
      idx_q  <= '0;
      prio_q <= '0;
    end else if (ack_ok || stk_full) begin
      req_q <= 1'b0;
    end else if (trap_pend_q) begin
      req_q  <= 1'b1;
      trap_q <= 1'b1;
      xfer_q <= 1'b0;
      vec_q  <= trap_num_q;
      prio_q <= cur_lvl;
    end else begin
      req_q  <= win_valid;
      trap_q <= 1'b0;
      xfer_q <= win_route;
      vec_q  <= VEC_W'(SRC_VEC_BASE) + VEC_W'(win_idx);
      idx_q  <= win_idx;
      prio_q <= win_prio;
    end
  end

  assign reg_rdata_o = (32'(reg_idx_i) < NUM_SRC) ? ctrl[reg_idx_i] : '0;
  assign irq_req_o   = req_q;
  assign irq_vec_o   = vec_q;
  assign irq_xfer_o  = xfer_q;
  assign irq_trap_o  = trap_q;
  assign cur_lvl_o   = cur_lvl;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned PRIO_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_req_o,
  input logic              irq_ack_i,
  input logic              irq_xfer_o,
  input logic              irq_trap_o,
  input logic [PRIO_W-1:0] cur_lvl_o,
  input logic [PRIO_W-1:0] win_prio_q,
  input logic              stk_full
);
  p_above_lvl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && !irq_trap_o |-> win_prio_q > cur_lvl_o);

  p_ack_drop_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && irq_ack_i |=> !irq_req_o);

  p_std_lvl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && irq_ack_i && !irq_xfer_o && !irq_trap_o |=> cur_lvl_o == $past(win_prio_q));

  p_xfer_lvl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && irq_ack_i && irq_xfer_o |=> $stable(cur_lvl_o));

  p_trap_lvl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o && irq_ack_i && irq_trap_o |=> $stable(cur_lvl_o));

  p_full_block_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_full |-> !irq_req_o);
endmodule

bind irq_ctrl irq_ctrl_chk #(.PRIO_W(irq_pkg::PRIO_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_req_o  (irq_req_o),
  .irq_ack_i  (irq_ack_i),
  .irq_xfer_o (irq_xfer_o),
  .irq_trap_o (irq_trap_o),
  .cur_lvl_o  (cur_lvl_o),
  .win_prio_q (prio_q),
  .stk_full   (stk_full)
);

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;
  localparam int NS = 8;
  localparam int DEPTH = 3;
  localparam int VW = 7;
  localparam int BASE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic we = 1'b0, trap = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [2:0] idx = '0;
  logic [6:0] wdata = '0, rdata;
  logic [VW-1:0] tnum_in = '0, vec;
  logic req, xfer, trp;
  logic [3:0] lvl;

  always #2.5 clk = ~clk;

  irq_ctrl #(.NUM_SRC(NS), .STACK_DEPTH(DEPTH), .VEC_W(VW), .SRC_VEC_BASE(BASE)) u_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(src_req), .reg_we_i(we), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trap_i(trap), .trap_num_i(tnum_in),
    .irq_req_o(req), .irq_vec_o(vec), .irq_xfer_o(xfer), .irq_trap_o(trp),
    .irq_ack_i(ack), .reti_i(reti), .cur_lvl_o(lvl));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // behavioural reference
  int  m_prio[NS];
  bit  m_req[NS], m_en[NS], m_rt[NS];
  int  stk[$];
  int  m_lvl = 0, m_tnum = 0;
  bit  m_tp = 0;
  bit  o_req = 0, o_xfer = 0, o_trap = 0;
  int  o_vec = 0, o_idx = 0, o_prio = 0;

  initial for (int i = 0; i < NS; i++) begin m_prio[i] = 0; m_req[i] = 0; m_en[i] = 0; m_rt[i] = 0; end

  always @(posedge clk) if (rst_n) begin
    bit ack_ok, full, n_req, n_xfer, n_trap;
    int w, n_vec, n_idx, n_prio;
    ack_ok = ack && o_req;
    full = (stk.size() == DEPTH);
    w = -1;
    for (int i = 0; i < NS; i++)
      if (m_req[i] && m_en[i] && m_prio[i] > m_lvl && (w < 0 || m_prio[i] > m_prio[w])) w = i;
    n_req = 0; n_xfer = o_xfer; n_trap = o_trap; n_vec = o_vec; n_idx = o_idx; n_prio = o_prio;
    if (!ack_ok && !full) begin
      if (m_tp) begin n_req = 1; n_trap = 1; n_xfer = 0; n_vec = m_tnum; n_prio = m_lvl; end
      else if (w >= 0) begin n_req = 1; n_trap = 0; n_xfer = m_rt[w]; n_vec = BASE + w; n_idx = w; n_prio = m_prio[w]; end
    end
    if (ack_ok) begin
      if (o_trap) stk.push_back(m_lvl);
      else begin
        m_req[o_idx] = 0;
        if (!o_xfer) begin stk.push_back(m_lvl); m_lvl = o_prio; end
      end
    end else if (reti) begin
      if (stk.size() > 0) m_lvl = stk.pop_back(); else m_lvl = 0;
    end
    if (trap) begin m_tp = 1; m_tnum = int'(tnum_in); end
    else if (ack_ok && o_trap) m_tp = 0;
    for (int i = 0; i < NS; i++) if (src_req[i]) m_req[i] = 1;
    if (we) begin
      m_rt[idx] = wdata[6]; m_req[idx] = wdata[5]; m_en[idx] = wdata[4]; m_prio[idx] = int'(wdata[3:0]);
    end
    o_req = n_req; o_xfer = n_xfer; o_trap = n_trap; o_vec = n_vec; o_idx = n_idx; o_prio = n_prio;
  end

  // cycle compare against the model
  always @(negedge clk) if (rst_n && !done) begin
    int exp_rd;
    exp_rd = (int'(m_rt[idx]) << 6) | (int'(m_req[idx]) << 5) | (int'(m_en[idx]) << 4) | m_prio[idx];
    chk(req == o_req && (!o_req || (int'(vec) == o_vec && xfer == o_xfer && trp == o_trap)),
        "R3 model req/vec", int'(req) * 1000 + int'(vec), int'(o_req) * 1000 + o_vec);
    chk(int'(lvl) == m_lvl, "R6 model level", int'(lvl), m_lvl);
    chk(int'(rdata) == exp_rd, "R10 model rdata", int'(rdata), exp_rd);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int i, input bit rt, input bit rq, input bit en, input int p);
    idx = 3'(i); wdata = {rt, rq, en, 4'(p)}; we = 1'b1;
    tick(1);
    we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; tick(1); reti = 1'b0;
  endtask

  task automatic do_trap(input int n);
    tnum_in = VW'(n); trap = 1'b1; tick(1); trap = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  initial begin
    tick(3);
    @(negedge clk);
    chk(req == 0 && lvl == 0 && rdata == 0, "R1 reset state", int'(req) + int'(lvl) + int'(rdata), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    tick(2);

    wr(3, 0, 1, 1, 5); tick(3);
    chk(req && int'(vec) == BASE + 3 && !xfer && !trp, "R5 vector of source 3", int'(vec), BASE + 3);
    do_ack();
    @(negedge clk);
    chk(!req, "R13 request drops after ack", int'(req), 0);
    chk(lvl == 5, "R6 level after standard ack", int'(lvl), 5);
    tick(1);

    wr(1, 0, 1, 1, 5); tick(4);
    chk(!req, "R4 equal level does not preempt", int'(req), 0);
    wr(2, 0, 1, 1, 0); wr(4, 0, 1, 0, 9); tick(4);
    chk(!req, "R2 prio 0 or disabled not presented", int'(req), 0);

    wr(6, 0, 1, 1, 9); wr(5, 0, 1, 1, 9); tick(3);
    chk(req && int'(vec) == BASE + 5, "R3 tie lowest index", int'(vec), BASE + 5);
    do_ack(); tick(1);
    chk(lvl == 9, "R6 nested level", int'(lvl), 9);
    do_reti(); tick(1);
    chk(lvl == 5, "R8 pop restores level", int'(lvl), 5);
    tick(2);
    chk(req && int'(vec) == BASE + 6, "R3 next source", int'(vec), BASE + 6);
    do_ack(); do_reti(); do_reti(); tick(3);
    chk(req && int'(vec) == BASE + 1, "R3 source 1 after level drops", int'(vec), BASE + 1);
    do_ack(); do_reti(); do_reti(); tick(1);
    chk(lvl == 0, "R8 empty stack gives level 0", int'(lvl), 0);

    wr(7, 1, 1, 1, 12); tick(3);
    chk(req && xfer && int'(vec) == BASE + 7, "R5 transfer routing", int'(xfer), 1);
    do_ack(); idx = 3'd7; tick(2);
    @(negedge clk);
    chk(lvl == 0, "R7 transfer keeps level", int'(lvl), 0);
    chk(rdata == 7'h5C, "R7 flag cleared by transfer ack", int'(rdata), 'h5C);
    tick(1);

    wr(3, 0, 1, 1, 6); tick(3); do_ack(); tick(1);
    do_trap(40); tick(2);
    chk(req && trp && !xfer && int'(vec) == 40, "R9 trap presented", int'(vec), 40);
    do_ack(); tick(1);
    chk(lvl == 6, "R9 trap keeps level", int'(lvl), 6);
    do_trap(41); tick(2); do_ack(); tick(1);
    do_trap(42); tick(4);
    chk(!req, "R12 full stack blocks", int'(req), 0);
    do_reti(); tick(3);
    chk(req && int'(vec) == 42, "R12 released after pop", int'(vec), 42);
    do_ack(); do_reti(); do_reti(); do_reti(); tick(2);

    wr(0, 0, 1, 1, 7); tick(3);
    idx = 3'd0; src_req[0] = 1'b1; ack = 1'b1; tick(1); src_req[0] = 1'b0; ack = 1'b0;
    @(negedge clk);
    chk(rdata[5] == 1'b1 && lvl == 7, "R11 set beats ack clear", int'(rdata[5]), 1);
    do_reti(); tick(3);
    chk(req && int'(vec) == BASE, "R11 source 0 again", int'(vec), BASE);
    do_ack(); do_reti(); tick(1);

    idx = 3'd2; wdata = 7'h13; we = 1'b1; src_req[2] = 1'b1; tick(1);
    we = 1'b0; src_req[2] = 1'b0;
    @(negedge clk);
    chk(rdata == 7'h13, "R10 write beats hw set", int'(rdata), 'h13);
    tick(4);
    report();
  end
endmodule